// File: doc/BRIEF.md
# Bus-Mapped Pad I/O Controller

This block turns a set of bidirectional pads into general-purpose I/O that a processor reaches through a 32-bit Wishbone slave port. Software sees three word registers inside a small address window: a read-only view of the pad levels, a register holding the level to drive on each pad, and a direction mask. Bit n of every register belongs to pad n. A direction bit of 1 turns the pad into an output. A 0 leaves the pad as a high-impedance input.

The controller drives a per-pad enable and a per-pad level toward external tristate buffers. It takes the pad levels back through a two-stage synchroniser. It claims only those accesses whose address lies in its window, which starts at byte address 0x04000 and spans 256 bytes. Every claimed access is acknowledged for one cycle, in the cycle after the strobe is seen. Read data arrives together with that acknowledge.

Top module: `wb_pad_gpio`

## Requirements
- R1: After reset the drive-level register and the direction mask are zero, so `padOe` and `padOut` are all low and `wbAck` is low.
- R2: A write to byte offset 0x04 stores the drive levels, and `padOut` bit n then follows bit n of that register.
- R3: A write to byte offset 0x08 stores the direction mask, and `padOe` bit n is 1 (pad n is an output) exactly when bit n of the mask is 1.
- R4: Reads of offsets 0x04 and 0x08 return the stored register contents, not the pad levels.
- R5: A read of offset 0x00 returns the pad levels, bit n being pad n, once they have been stable for two clock edges. This holds whatever the pad's direction.
- R6: A write to offset 0x00 changes no register: `padOut` and `padOe` keep their values, and the input readback still reflects the pads.
- R7: Each strobed access (`wbCyc` and `wbStb` high) that falls in the window gets `wbAck` high for exactly one cycle, in the cycle after the strobe is first seen. Read data is valid in that same cycle.
- R8: An access whose address bits 16 to 8 differ from 0x04000's is not acknowledged and changes no register.
- R9: Inside the window, reads of offsets other than 0x00, 0x04 and 0x08 return zero, and writes to them change nothing. Both kinds are still acknowledged.
- R10: On a write, `wbSel` bit k enables byte k (data bits 8k+7 to 8k). Bytes whose select bit is low keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Strobe for this slave |
| wbWe | input | 1 | 1 = write, 0 = read |
| wbAddr | input | 17 | Byte address in the fabric space |
| wbSel | input | 4 | Byte selects for writes |
| wbDatW | input | 32 | Write data |
| wbDatR | output | 32 | Read data, valid with `wbAck` |
| wbAck | output | 1 | One-cycle acknowledge |
| padIn | input | 32 | Levels sampled at the pads |
| padOut | output | 32 | Levels to drive on the pads |
| padOe | output | 32 | Per-pad output enable |

## Verification
Faults in the stored registers reach the pins directly. A wrong drive or direction bit appears on `padOut` or `padOe` at the edge that performs the write, and it is seen again on the next readback. A fault in the acknowledge state shows up at once: the acknowledge is missing, lasts two cycles, or appears for an address outside the window, all within one cycle of the strobe. A fault in the synchroniser or the read multiplexer shows up as wrong read data in the acknowledge cycle of the first read after the pads settle.

// File: rtl/wb_pad_gpio_pkg.sv
package wb_pad_gpio_pkg;

  typedef enum logic [1:0] {
    SEL_PADS  = 2'd0,
    SEL_DRIVE = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrDrive;
    logic    wrDir;
    logic    rdLoad;
    regSel_e sel;
  } gpioStrobe_t;

endpackage

// File: rtl/wb_pad_gpio_ctrl.sv
module wb_pad_gpio_ctrl
  import wb_pad_gpio_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int WIN_BITS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 17'h04000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAddr,
  output logic              wbAck,
  output gpioStrobe_t       strobe
);

  localparam int WORD_BITS = WIN_BITS - 2;

  logic                 inWindow;
  logic                 request;
  logic [WORD_BITS-1:0] wordIdx;
  regSel_e              decodedSel;

  assign inWindow = (wbAddr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
  assign request  = wbCyc && wbStb && inWindow && !wbAck;
  assign wordIdx  = wbAddr[WIN_BITS-1:2];

  always_comb begin
    case (wordIdx)
      WORD_BITS'(0): decodedSel = SEL_PADS;
      WORD_BITS'(1): decodedSel = SEL_DRIVE;
      WORD_BITS'(2): decodedSel = SEL_DIR;
      default:       decodedSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe.sel     = decodedSel;
    strobe.wrDrive = request && wbWe && (decodedSel == SEL_DRIVE);
    strobe.wrDir   = request && wbWe && (decodedSel == SEL_DIR);
    strobe.rdLoad  = request && !wbWe;
  end

  always_ff @(posedge clk) begin
    if (rst) wbAck <= 1'b0;
    else     wbAck <= request;
  end

endmodule

// File: rtl/wb_pad_gpio_datapath.sv
module wb_pad_gpio_datapath
  import wb_pad_gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  gpioStrobe_t           strobe,
  input  logic [DATA_W/8-1:0]   wbSel,
  input  logic [DATA_W-1:0]     wbDatW,
  output logic [DATA_W-1:0]     wbDatR,
  input  logic [DATA_W-1:0]     padIn,
  output logic [DATA_W-1:0]     padOut,
  output logic [DATA_W-1:0]     padOe
);

  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] driveReg;
  logic [DATA_W-1:0] dirReg;
  logic [DATA_W-1:0] syncStage1;
  logic [DATA_W-1:0] syncStage2;
  logic [DATA_W-1:0] readMux;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncStage1 <= '0;
      syncStage2 <= '0;
    end else begin
      syncStage1 <= padIn;
      syncStage2 <= syncStage1;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byteLane
    always_ff @(posedge clk) begin
      if (rst) begin
        driveReg[8*b +: 8] <= '0;
        dirReg[8*b +: 8]   <= '0;
      end else begin
        if (strobe.wrDrive && wbSel[b]) driveReg[8*b +: 8] <= wbDatW[8*b +: 8];
        if (strobe.wrDir && wbSel[b])   dirReg[8*b +: 8]   <= wbDatW[8*b +: 8];
      end
    end
  end

  always_comb begin
    case (strobe.sel)
      SEL_PADS:  readMux = syncStage2;
      SEL_DRIVE: readMux = driveReg;
      SEL_DIR:   readMux = dirReg;
      default:   readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                wbDatR <= '0;
    else if (strobe.rdLoad) wbDatR <= readMux;
  end

  assign padOut = driveReg;
  assign padOe  = dirReg;

endmodule

// File: rtl/wb_pad_gpio.sv
module wb_pad_gpio
  import wb_pad_gpio_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 17'h04000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wbCyc,
  input  logic                wbStb,
  input  logic                wbWe,
  input  logic [ADDR_W-1:0]   wbAddr,
  input  logic [DATA_W/8-1:0] wbSel,
  input  logic [DATA_W-1:0]   wbDatW,
  output logic [DATA_W-1:0]   wbDatR,
  output logic                wbAck,
  input  logic [DATA_W-1:0]   padIn,
  output logic [DATA_W-1:0]   padOut,
  output logic [DATA_W-1:0]   padOe
);

  gpioStrobe_t strobe;

  wb_pad_gpio_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAddr(wbAddr), .wbAck(wbAck), .strobe(strobe)
  );

  wb_pad_gpio_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .wbSel(wbSel), .wbDatW(wbDatW),
    .wbDatR(wbDatR), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

endmodule

// File: rtl/wb_pad_gpio_chk.sv
module wb_pad_gpio_chk #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 17'h04000
) (
  input logic                clk,
  input logic                rst,
  input logic                wbCyc,
  input logic                wbStb,
  input logic                wbWe,
  input logic [ADDR_W-1:0]   wbAddr,
  input logic [DATA_W-1:0]   wbDatR,
  input logic                wbAck,
  input logic [DATA_W-1:0]   padOut,
  input logic [DATA_W-1:0]   padOe
);

  logic hit;
  logic oddOffset;
  logic padsOffset;

  assign hit        = wbCyc && wbStb && (wbAddr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
  assign padsOffset = (wbAddr[WIN_BITS-1:2] == '0);
  assign oddOffset  = (wbAddr[WIN_BITS-1:2] > (WIN_BITS-2)'(2));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);

  assert_ack_caused_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wbAck) |-> $past(hit));

  assert_no_ack_outside_R8: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !hit) |=> !wbAck);

  assert_drive_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(hit && wbWe) |=> $stable(padOut));

  assert_dir_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !(hit && wbWe) |=> $stable(padOe));

  assert_pads_readonly_R6: assert property (@(posedge clk) disable iff (rst)
    (hit && wbWe && padsOffset) |=> ($stable(padOut) && $stable(padOe)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (hit && !wbWe && oddOffset && !wbAck) |=> (wbDatR == '0));

endmodule

bind wb_pad_gpio wb_pad_gpio_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
  .wbAddr(wbAddr), .wbDatR(wbDatR), .wbAck(wbAck), .padOut(padOut), .padOe(padOe)
);

// File: tb/test_wb_pad_gpio.sv
module test_wb_pad_gpio;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [16:0] wbAddr = '0;
  logic [3:0]  wbSel = '0;
  logic [31:0] wbDatW = '0;
  logic [31:0] wbDatR;
  logic        wbAck;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;

  int checks = 0;
  int errors = 0;

  localparam logic [16:0] BASE = 17'h04000;

  always #4 clk = ~clk;

  wb_pad_gpio i_wb_pad_gpio (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAddr(wbAddr), .wbSel(wbSel), .wbDatW(wbDatW), .wbDatR(wbDatR),
    .wbAck(wbAck), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One strobed access; reports ack in the cycle after the strobe and one cycle later.
  task automatic access(input logic we, input logic [16:0] addr, input logic [31:0] data,
                        input logic [3:0] sel, output logic ack1, output logic ack2,
                        output logic [31:0] rd);
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = we; wbAddr = addr; wbDatW = data; wbSel = sel;
    @(negedge clk);
    ack1 = wbAck; rd = wbDatR;
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    @(negedge clk);
    ack2 = wbAck;
  endtask

  task automatic wr(input string req, input logic [16:0] addr, input logic [31:0] data, input logic [3:0] sel);
    logic a1, a2;
    logic [31:0] rd;
    access(1'b1, addr, data, sel, a1, a2, rd);
    checkEq(req, {31'd0, a1}, 32'd1);
  endtask

  task automatic rdChk(input string req, input logic [16:0] addr, input logic [31:0] exp);
    logic a1, a2;
    logic [31:0] rd;
    access(1'b0, addr, 32'd0, 4'h0, a1, a2, rd);
    checkEq(req, {31'd0, a1}, 32'd1);
    checkEq(req, rd, exp);
  endtask

  task automatic testReset;
    checkEq("R1 padOut", padOut, 32'd0);
    checkEq("R1 padOe", padOe, 32'd0);
    checkEq("R1 ack", {31'd0, wbAck}, 32'd0);
    rdChk("R1 drive readback", BASE + 17'h04, 32'd0);
    rdChk("R1 dir readback", BASE + 17'h08, 32'd0);
  endtask

  task automatic testDriveDir;
    wr("R2 write ack", BASE + 17'h04, 32'hA5C3_0F81, 4'hF);
    checkEq("R2 padOut", padOut, 32'hA5C3_0F81);
    wr("R3 write ack", BASE + 17'h08, 32'h00FF_F00F, 4'hF);
    checkEq("R3 padOe", padOe, 32'h00FF_F00F);
    rdChk("R4 drive readback", BASE + 17'h04, 32'hA5C3_0F81);
    rdChk("R4 dir readback", BASE + 17'h08, 32'h00FF_F00F);
  endtask

  task automatic testByteSel;
    wr("R10 write", BASE + 17'h04, 32'h1122_3344, 4'b0101);
    checkEq("R10 padOut", padOut, 32'hA522_0F44);
    wr("R10 write dir", BASE + 17'h08, 32'hFFFF_FFFF, 4'b1000);
    checkEq("R10 padOe", padOe, 32'hFFFF_F00F);
  endtask

  task automatic testPads;
    padIn = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rdChk("R5 pads", BASE, 32'hDEAD_BEEF);
    padIn = 32'h0000_0001;
    repeat (3) @(negedge clk);
    // pad 0 is an output here; level at the pad is still returned
    rdChk("R5 pads output dir", BASE, 32'h0000_0001);
  endtask

  task automatic testReadOnly;
    wr("R6 ack", BASE, 32'h5555_5555, 4'hF);
    checkEq("R6 padOut", padOut, 32'hA522_0F44);
    checkEq("R6 padOe", padOe, 32'hFFFF_F00F);
    rdChk("R6 pads", BASE, 32'h0000_0001);
  endtask

  task automatic testAck;
    logic a1, a2;
    logic [31:0] rd;
    access(1'b0, BASE + 17'h04, 32'd0, 4'h0, a1, a2, rd);
    checkEq("R7 ack in next cycle", {31'd0, a1}, 32'd1);
    checkEq("R7 ack one cycle", {31'd0, a2}, 32'd0);
    @(negedge clk);
    wbCyc = 1'b0; wbStb = 1'b1; wbAddr = BASE + 17'h04;
    @(negedge clk);
    checkEq("R7 no ack without cyc", {31'd0, wbAck}, 32'd0);
    wbStb = 1'b0;
  endtask

  task automatic testWindow;
    logic a1, a2;
    logic [31:0] rd;
    access(1'b1, 17'h04104, 32'h0, 4'hF, a1, a2, rd);
    checkEq("R8 no ack above", {31'd0, a1 | a2}, 32'd0);
    access(1'b1, 17'h00008, 32'h0, 4'hF, a1, a2, rd);
    checkEq("R8 no ack other", {31'd0, a1 | a2}, 32'd0);
    checkEq("R8 padOut kept", padOut, 32'hA522_0F44);
    checkEq("R8 padOe kept", padOe, 32'hFFFF_F00F);
  endtask

  task automatic testUnmapped;
    rdChk("R9 read 0x0C", BASE + 17'h0C, 32'd0);
    rdChk("R9 read 0xFC", BASE + 17'hFC, 32'd0);
    wr("R9 write ack", BASE + 17'h10, 32'h0, 4'hF);
    checkEq("R9 padOut kept", padOut, 32'hA522_0F44);
    checkEq("R9 padOe kept", padOe, 32'hFFFF_F00F);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testDriveDir();
    testByteSel();
    testPads();
    testReadOnly();
    testAck();
    testWindow();
    testUnmapped();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule